// File: doc/BRIEF.md
# Ring Completion Counter with Coalesced Interrupt

This block keeps the completion count of one output ring and decides when software should be interrupted. Each completion event arrives on a strobe. In packet mode an event adds one to the count. In byte mode it adds the byte amount carried with the event. Software acknowledges work by writing an amount that the block subtracts from the count; the write never loads the count directly.

An age timer runs only while completions are pending. It is clocked by a prescaler, so it measures how long work has been waiting. The interrupt flag rises when the backlog exceeds a programmed count limit or when the age exceeds a programmed time limit. Every rising edge of the flag produces a one-cycle request pulse. Software can ask for the request again through a resend bit, which takes effect only if a limit is still exceeded.

The register port has two word addresses behind a single write strobe. Address 0 is the status word: reads return the count, age and flag, and writes subtract and may resend. Address 1 is the configuration word, which holds both limits and the counting mode.

Top module: `cmpl_coalesce`

## Requirements
- R1: After a synchronous reset the count, age timer, prescaler, flag, both limits and the mode bit are zero, and `irq` and `irq_req` are low.
- R2: In packet mode (configuration bit 63 = 0), each cycle with `evt_valid` high adds exactly one to the count.
- R3: In byte mode (configuration bit 63 = 1), each cycle with `evt_valid` high adds `evt_bytes` to the count.
- R4: A write to address 0 subtracts `reg_wdata[31:0]` from the count. If an event arrives in the same cycle, both the addition and the subtraction are applied.
- R5: The count never goes below zero or above its maximum (all ones of `CNT_W` bits). A result out of range is clamped to the nearest of these two bounds.
- R6: While the count is nonzero, the age timer advances by one every `PRESCALE` cycles. It first reads 1 `PRESCALE` cycles after the count leaves zero, and it holds at its maximum instead of wrapping.
- R7: In the cycle the count becomes zero, the age timer, the prescaler and the flag all become zero.
- R8: The flag (`irq`, status bit 61) is high exactly when count > count limit (configuration bits 31:0) or age > time limit (configuration bits 53:32). Both comparisons are strict.
- R9: `irq_req` pulses high for one cycle in the same cycle that `irq` rises.
- R10: A write to address 0 with bit 60 set pulses `irq_req` for one cycle if the flag is still high after that write. If the flag is low after the write, no pulse occurs.
- R11: Reads are combinational. Address 0 returns count in bits 31:0, age in bits 53:32 and the flag in bit 61, with all other bits zero. Address 1 returns the stored configuration word, with bits 62:54 reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | One completion event this cycle |
| evt_bytes | input | EVT_W | Byte amount of the event, used in byte mode |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Word select: 0 status/acknowledge, 1 configuration |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` |
| irq | output | 1 | Coalesced interrupt flag |
| irq_req | output | 1 | One-cycle interrupt request pulse |

## Verification
The bench goes after the following corner cases:
- **Count exactly at the limit.** A design using a non-strict compare would interrupt one completion early.
- **Event and acknowledge in the same cycle.** Letting one win would leave the count off by one.
- **Acknowledging more than is pending, and accumulating past the top.** A wrapping counter would show a huge or a tiny backlog.
- **Age timer at one prescale boundary short of the time limit and then one past it.** A misaligned prescaler shifts the interrupt by a cycle, and a timer that wraps re-arms the age condition falsely.
- **Resend with the condition held and with it cleared.** A design that ignores the condition would issue spurious requests.

Random traffic with changing limits and modes is then compared cycle by cycle against a bench model.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;

    // Register word layout
    localparam int REG_W       = 64;
    localparam int FLD_CNT_W   = 32;
    localparam int FLD_TMR_W   = 22;
    localparam int FLD_TMR_LSB = 32;
    localparam int BIT_RESEND  = 60;
    localparam int BIT_FLAG    = 61;
    localparam int BIT_MODE    = 63;

    typedef enum logic {
        ADDR_STAT = 1'b0,
        ADDR_CFG  = 1'b1
    } reg_addr_e;

    typedef struct packed {
        logic                 byte_mode;
        logic [FLD_TMR_W-1:0] time_lim;
        logic [FLD_CNT_W-1:0] cnt_lim;
    } lim_cfg_t;

    // cur + inc - sub, clamped into [0, maxv]
    function automatic logic [31:0] clamp_addsub(
        input logic [31:0] cur,
        input logic [31:0] inc,
        input logic [31:0] sub,
        input logic [31:0] maxv
    );
        logic signed [34:0] t;
        t = $signed({3'b000, cur}) + $signed({3'b000, inc}) - $signed({3'b000, sub});
        if (t < 35'sd0)
            return 32'd0;
        else if (t > $signed({3'b000, maxv}))
            return maxv;
        else
            return t[31:0];
    endfunction

    function automatic logic [REG_W-1:0] pack_status(
        input logic                 flag,
        input logic [FLD_TMR_W-1:0] age,
        input logic [FLD_CNT_W-1:0] cnt
    );
        return {2'b00, flag, 1'b0, 6'b000000, age, cnt};
    endfunction

    function automatic logic [REG_W-1:0] pack_cfg(input lim_cfg_t c);
        return {c.byte_mode, 9'd0, c.time_lim, c.cnt_lim};
    endfunction

    function automatic lim_cfg_t unpack_cfg(input logic [REG_W-1:0] w);
        lim_cfg_t c;
        c.byte_mode = w[BIT_MODE];
        c.time_lim  = w[FLD_TMR_LSB +: FLD_TMR_W];
        c.cnt_lim   = w[FLD_CNT_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/cc_counter.sv
module cc_counter
    import cmpl_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int EVT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_valid,
    input  logic [EVT_W-1:0] evt_bytes,
    input  logic             byte_mode,
    input  logic             sub_en,
    input  logic [31:0]      sub_amt,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;
    localparam logic [31:0]      CNT_TOP32 = 32'(CNT_TOP);

    logic [31:0] inc_amt;
    logic [31:0] dec_amt;
    logic [31:0] sum32;

    always_comb begin
        if (!evt_valid)
            inc_amt = 32'd0;
        else if (byte_mode)
            inc_amt = 32'(evt_bytes);
        else
            inc_amt = 32'd1;
        dec_amt  = sub_en ? sub_amt : 32'd0;
        sum32    = clamp_addsub(32'(cnt_q), inc_amt, dec_amt, CNT_TOP32);
        cnt_next = sum32[CNT_W-1:0];
    end

    logic [31:0] sum_unused;
    assign sum_unused = sum32;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_next;
    end

endmodule

// File: rtl/cc_age.sv
module cc_age #(
    parameter int TMR_W    = 22,
    parameter int PRESCALE = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    output logic [TMR_W-1:0] tmr_q,
    output logic [TMR_W-1:0] tmr_next
);
    localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
    localparam logic [TMR_W-1:0] TMR_TOP  = '1;
    localparam bit   PRE_POW2 = (PRESCALE & (PRESCALE - 1)) == 0;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_next;
    logic             tick;

    // A power-of-two prescale needs only an AND-reduce; others compare
    generate
        if (PRE_POW2) begin : g_pow2
            assign tick = &pre_q;
        end else begin : g_cmp
            assign tick = (pre_q == PRE_LAST);
        end
    endgenerate

    always_comb begin
        if (!run) begin
            pre_next = '0;
            tmr_next = '0;
        end else if (tick) begin
            pre_next = '0;
            tmr_next = (tmr_q == TMR_TOP) ? tmr_q : tmr_q + TMR_W'(1);
        end else begin
            pre_next = pre_q + PRE_W'(1);
            tmr_next = tmr_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
            tmr_q <= '0;
        end else begin
            pre_q <= pre_next;
            tmr_q <= tmr_next;
        end
    end

endmodule

// File: rtl/cc_irq.sv
module cc_irq
    import cmpl_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int TMR_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic [TMR_W-1:0] tmr_next,
    input  lim_cfg_t         lim_next,
    input  logic             resend,
    output logic             flag_q,
    output logic             req_q
);
    logic over_cnt;
    logic over_age;
    logic flag_next;

    always_comb begin
        over_cnt  = 32'(cnt_next) > lim_next.cnt_lim;
        over_age  = FLD_TMR_W'(tmr_next) > lim_next.time_lim;
        flag_next = over_cnt || over_age;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            req_q  <= 1'b0;
        end else begin
            flag_q <= flag_next;
            req_q  <= flag_next && (!flag_q || resend);
        end
    end

endmodule

// File: rtl/cmpl_coalesce.sv
module cmpl_coalesce
    import cmpl_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int TMR_W    = 22,
    parameter int EVT_W    = 16,
    parameter int PRESCALE = 2048
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt_valid,
    input  logic [EVT_W-1:0] evt_bytes,
    input  logic             reg_wr,
    input  logic             reg_addr,
    input  logic [63:0]      reg_wdata,
    output logic [63:0]      reg_rdata,
    output logic             irq,
    output logic             irq_req
);
    logic             sub_en;
    logic             cfg_wr;
    logic             resend;
    lim_cfg_t         lim_q;
    lim_cfg_t         lim_next;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic [TMR_W-1:0] tmr_q;
    logic [TMR_W-1:0] tmr_next;
    logic             age_run;

    always_comb begin
        sub_en   = reg_wr && (reg_addr == ADDR_STAT);
        cfg_wr   = reg_wr && (reg_addr == ADDR_CFG);
        resend   = sub_en && reg_wdata[BIT_RESEND];
        lim_next = cfg_wr ? unpack_cfg(reg_wdata) : lim_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            lim_q <= '0;
        else
            lim_q <= lim_next;
    end

    cc_counter #(.CNT_W(CNT_W), .EVT_W(EVT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .evt_valid (evt_valid),
        .evt_bytes (evt_bytes),
        .byte_mode (lim_q.byte_mode),
        .sub_en    (sub_en),
        .sub_amt   (reg_wdata[31:0]),
        .cnt_q     (cnt_q),
        .cnt_next  (cnt_next)
    );

    // Age runs only while work stays pending across this edge
    assign age_run = (cnt_q != '0) && (cnt_next != '0);

    cc_age #(.TMR_W(TMR_W), .PRESCALE(PRESCALE)) u_age (
        .clk      (clk),
        .rst      (rst),
        .run      (age_run),
        .tmr_q    (tmr_q),
        .tmr_next (tmr_next)
    );

    cc_irq #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .cnt_next (cnt_next),
        .tmr_next (tmr_next),
        .lim_next (lim_next),
        .resend   (resend),
        .flag_q   (irq),
        .req_q    (irq_req)
    );

    always_comb begin
        if (reg_addr == ADDR_CFG)
            reg_rdata = pack_cfg(lim_q);
        else
            reg_rdata = pack_status(irq, FLD_TMR_W'(tmr_q), FLD_CNT_W'(cnt_q));
    end

    logic wdata_unused;
    assign wdata_unused = ^{reg_wdata[62:61], reg_wdata[59:54]};

endmodule

// File: rtl/cmpl_coalesce_chk.sv
module cmpl_coalesce_chk #(
    parameter int CNT_W = 32,
    parameter int TMR_W = 22
) (
    input logic             clk,
    input logic             rst,
    input logic             evt_valid,
    input logic             byte_mode,
    input logic             sub_en,
    input logic [CNT_W-1:0] cnt_q,
    input logic [TMR_W-1:0] tmr_q,
    input logic             irq,
    input logic             irq_req
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    // R7: an empty ring carries no age and no interrupt
    a_r7_zero_clears: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0) |-> (!irq && tmr_q == '0));

    // R6: age moves only by single steps upward or back to zero
    a_r6_age_step: assert property (@(posedge clk) disable iff (rst)
        (tmr_q != $past(tmr_q)) |-> (tmr_q == $past(tmr_q) + TMR_W'(1) || tmr_q == '0));

    // R9: a rising flag always comes with a request
    a_r9_req_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> irq_req);

    // R9, R10: no request without the flag
    a_r10_req_needs_flag: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> irq);

    // R2: packet-mode event with no acknowledge adds one
    a_r2_pkt_step: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && !byte_mode && !sub_en && cnt_q != CNT_TOP)
        |=> ((cnt_q - $past(cnt_q)) == CNT_W'(1)));

    // R4: without an event or an acknowledge the count holds
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!evt_valid && !sub_en) |=> $stable(cnt_q));

endmodule

bind cmpl_coalesce cmpl_coalesce_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_valid (evt_valid),
    .byte_mode (lim_q.byte_mode),
    .sub_en    (sub_en),
    .cnt_q     (cnt_q),
    .tmr_q     (tmr_q),
    .irq       (irq),
    .irq_req   (irq_req)
);

// File: tb/cmpl_coalesce_test.sv
module cmpl_coalesce_test;
    localparam int CW   = 12;
    localparam int TW   = 5;
    localparam int EW   = 8;
    localparam int PS   = 16;
    localparam longint CMAX = (64'd1 << CW) - 1;
    localparam int TMAX = (1 << TW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          evt_valid = 1'b0;
    logic [EW-1:0] evt_bytes = '0;
    logic          reg_wr = 1'b0;
    logic          reg_addr = 1'b0;
    logic [63:0]   reg_wdata = '0;
    logic [63:0]   reg_rdata;
    logic          irq;
    logic          irq_req;

    int n_chk = 0;
    int n_bad = 0;

    cmpl_coalesce #(.CNT_W(CW), .TMR_W(TW), .EVT_W(EW), .PRESCALE(PS)) uut (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_bytes(evt_bytes),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .irq_req(irq_req)
    );

    always #5 clk = ~clk;

    // Bench model built from the requirements
    longint m_cnt, m_pre, m_tmr, m_lc, m_lt;
    logic   m_bm, m_flag, m_req;

    always @(posedge clk) begin
        longint inc, sub, t, np, nt, nlc, nlt;
        logic   nbm, nf;
        if (rst) begin
            m_cnt = 0; m_pre = 0; m_tmr = 0; m_lc = 0; m_lt = 0;
            m_bm = 0; m_flag = 0; m_req = 0;
        end else begin
            inc = evt_valid ? (m_bm ? longint'(evt_bytes) : 1) : 0;
            sub = (reg_wr && !reg_addr) ? longint'(reg_wdata[31:0]) : 0;
            t = m_cnt + inc - sub;
            if (t < 0) t = 0;
            if (t > CMAX) t = CMAX;
            if (m_cnt == 0 || t == 0) begin
                np = 0; nt = 0;
            end else if (m_pre == PS - 1) begin
                np = 0; nt = (m_tmr == TMAX) ? m_tmr : m_tmr + 1;
            end else begin
                np = m_pre + 1; nt = m_tmr;
            end
            nlc = m_lc; nlt = m_lt; nbm = m_bm;
            if (reg_wr && reg_addr) begin
                nlc = longint'(reg_wdata[31:0]);
                nlt = longint'(reg_wdata[53:32]);
                nbm = reg_wdata[63];
            end
            nf = (t > nlc) || (nt > nlt);
            m_req = (nf && !m_flag) || (reg_wr && !reg_addr && reg_wdata[60] && nf);
            m_cnt = t; m_pre = np; m_tmr = nt; m_lc = nlc; m_lt = nlt; m_bm = nbm;
            m_flag = nf;
        end
    end

    function automatic logic [63:0] model_read(input logic a);
        if (a)
            return {m_bm, 9'd0, 22'(m_lt), 32'(m_lc)};
        else
            return {2'b00, m_flag, 1'b0, 6'd0, 22'(m_tmr), 32'(m_cnt)};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic ev, input int unsigned b, input logic wr,
                       input logic a, input logic [63:0] d);
        evt_valid = ev; evt_bytes = EW'(b); reg_wr = wr; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        chk("R8 irq vs model", 64'(irq), 64'(m_flag));
        chk("R9 irq_req vs model", 64'(irq_req), 64'(m_req));
        chk("R11 read vs model", reg_rdata, model_read(reg_addr));
    endtask

    task automatic rd(input logic a, output logic [63:0] v);
        evt_valid = 1'b0; reg_wr = 1'b0; reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 1'b0, 1'b0, 64'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [63:0] v;
        void'($urandom(32'h1C0A1E5C));
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(1'b0, v); chk("R1 status after reset", v, 64'd0);
        rd(1'b1, v); chk("R1 config after reset", v, 64'd0);
        chk("R1 irq after reset", 64'(irq), 64'd0);

        // count limit 3, time limit 2, packet mode
        cyc(1'b0, 0, 1'b1, 1'b1, 64'h0000_0002_0000_0003);
        rd(1'b1, v); chk("R11 config readback", v, 64'h0000_0002_0000_0003);

        // R2 and R8: 3 events sit at the limit, the 4th exceeds it
        cyc(1'b1, 0, 1'b0, 1'b0, 64'd0);
        cyc(1'b1, 0, 1'b0, 1'b0, 64'd0);
        cyc(1'b1, 0, 1'b0, 1'b0, 64'd0);
        chk("R8 count equal to limit is quiet", 64'(irq), 64'd0);
        cyc(1'b1, 0, 1'b0, 1'b0, 64'd0);
        chk("R8 count above limit", 64'(irq), 64'd1);
        chk("R9 request on rise", 64'(irq_req), 64'd1);
        rd(1'b0, v); chk("R2 four packets counted", v, 64'h2000_0000_0000_0004);
        cyc(1'b0, 0, 1'b0, 1'b0, 64'd0);
        chk("R9 request lasts one cycle", 64'(irq_req), 64'd0);

        // R4: subtract, then event plus subtract in one cycle
        cyc(1'b0, 0, 1'b1, 1'b0, 64'd1);
        chk("R8 back at limit clears flag", 64'(irq), 64'd0);
        rd(1'b0, v); chk("R4 subtract one", v, 64'd3);
        cyc(1'b1, 0, 1'b1, 1'b0, 64'd1);
        rd(1'b0, v); chk("R4 event and subtract together", v, 64'd3);
        cyc(1'b1, 0, 1'b1, 1'b0, 64'd2);
        rd(1'b0, v); chk("R4 event and larger subtract", v, 64'd2);

        // R5 low clamp, R7 clear
        cyc(1'b0, 0, 1'b1, 1'b0, 64'd100);
        rd(1'b0, v); chk("R5 R7 over-acknowledge clamps to zero", v, 64'd0);

        // R6: age from a single pending completion
        cyc(1'b1, 0, 1'b0, 1'b0, 64'd0);
        idle(3 * PS - 1);
        rd(1'b0, v); chk("R6 age two, one cycle before the third step", v, (64'd2 << 32) | 64'd1);
        chk("R8 age equal to limit is quiet", 64'(irq), 64'd0);
        idle(1);
        rd(1'b0, v); chk("R6 age three", v, (64'd1 << 61) | (64'd3 << 32) | 64'd1);
        chk("R8 age above limit", 64'(irq), 64'd1);
        chk("R9 request on age rise", 64'(irq_req), 64'd1);

        // R10: resend while condition holds, then with it cleared
        cyc(1'b0, 0, 1'b1, 1'b0, 64'd1 << 60);
        chk("R10 resend while flagged", 64'(irq_req), 64'd1);
        idle(1);
        chk("R10 resend pulse is single", 64'(irq_req), 64'd0);
        cyc(1'b0, 0, 1'b1, 1'b0, (64'd1 << 60) | 64'd1);
        chk("R10 resend after clearing", 64'(irq_req), 64'd0);
        rd(1'b0, v); chk("R7 age and flag cleared at zero", v, 64'd0);

        // R6: age holds at its top value
        cyc(1'b0, 0, 1'b1, 1'b1, (64'd31 << 32) | 64'd100);
        cyc(1'b1, 0, 1'b0, 1'b0, 64'd0);
        idle(32 * PS + 10);
        rd(1'b0, v); chk("R6 age saturates", v, (64'd31 << 32) | 64'd1);
        cyc(1'b0, 0, 1'b1, 1'b0, 64'd1);

        // R3 byte mode, R5 high clamp
        cyc(1'b0, 0, 1'b1, 1'b1, (64'd1 << 63) | (64'd31 << 32) | 64'd100);
        cyc(1'b1, 200, 1'b0, 1'b0, 64'd0);
        rd(1'b0, v); chk("R3 byte amount added", v & 64'hFFFF_FFFF, 64'd200);
        chk("R3 byte count above limit", 64'(irq), 64'd1);
        for (int i = 0; i < 20; i++) cyc(1'b1, 250, 1'b0, 1'b0, 64'd0);
        rd(1'b0, v); chk("R5 count clamps at top", v & 64'hFFFF_FFFF, 64'(CMAX));
        cyc(1'b0, 0, 1'b1, 1'b0, 64'd5000);

        // Random traffic checked against the model
        for (int i = 0; i < 4000; i++) begin
            logic        ev, wr, a;
            logic [63:0] d;
            ev = ($urandom_range(0, 1) == 1);
            wr = ($urandom_range(0, 9) == 0);
            a  = ($urandom_range(0, 3) == 0);
            if (a)
                d = {1'($urandom_range(0, 1)), 9'd0, 22'($urandom_range(0, 6)),
                     32'($urandom_range(0, 300))};
            else
                d = {3'd0, 1'($urandom_range(0, 1)), 28'd0, 32'($urandom_range(0, 300))};
            cyc(ev, $urandom_range(0, 255), wr, a, d);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule